// File: doc/BRIEF.md
# Multi-Channel Compare-Match Interval Timer

This block is a timer peripheral with several independent channels behind a simple register bus. Each channel has an up-counter, a compare register and a control/status register. A single run register, shared by every channel, holds one run bit per channel. While its run bit is set, a channel advances its counter once per prescaled tick. When the counter equals the compare value on a tick, the counter restarts from zero, a match flag is latched, and an interrupt request is raised if the channel's interrupt enable is set.

A build parameter selects a narrow (16-bit) or a wide (32-bit) variant. The variant fixes the register spacing, the counter width, the position of the match flag and the prescale ratio. Software clears a flag by writing zero to its bit. The compare register may be rewritten while the channel runs. A typical driver loads the counter with zero and the compare register with all ones to get the longest period, then shortens the compare value on the fly to schedule the next event.

Top module: `cmt_timer`

## Requirements
- R1: After reset every counter reads 0, every compare register reads all ones (0xFFFF narrow, 0xFFFFFFFF wide), every control/status register reads 0, the run register reads 0 and no interrupt is raised.
- R2: The run register is at byte address 0x00. Channel c occupies 0x10*(c+1) to 0x10*(c+1)+15. Inside that window, control/status is at offset 0, the counter at offset S and the compare register at offset 2*S, where S is 2 in the narrow variant and 4 in the wide variant. Reads of any other address return 0.
- R3: In the narrow variant every register holds 16 bits. In the wide variant the counter and compare registers hold 32 bits and control/status holds 16 bits. Write-data bits above a register's width are dropped, and reads are zero-extended to 32 bits.
- R4: Bit c of the run register makes channel c count while it is 1. Writing the run register leaves the counters of channels whose bit does not change untouched, and the register reads back as written.
- R5: A running channel's counter advances once every 512 clocks (narrow) or every 8 clocks (wide). The first advance comes that many clocks after the clock edge that sets the run bit. Clearing the run bit resets the prescaler, so a restart again waits a full prescale period.
- R6: On a tick where the counter equals the compare value, the counter loads 0 and the match flag is set: control/status bit 7 (narrow) or bit 15 (wide).
- R7: A compare value written while the channel runs governs the next match.
- R8: The interrupt output of a channel is high exactly when its match flag and its interrupt enable (control/status bit 6) are both 1. Writing 0 to control/status turns the interrupt off even if a later match sets the flag.
- R9: A status flag is cleared by writing 0 to its bit, and writing 1 leaves it unchanged. If a hardware set and a software clear fall in the same cycle, the flag ends up set.
- R10: In the wide variant, control/status bit 14 is a wrap flag. It is set when a tick moves the counter from all ones to zero without a match, and it does not raise the interrupt.
- R11: Counter and compare writes take effect at the clock edge of the write. Read data appears one cycle after the read strobe and shows the live counter. A counter write in the same cycle as a tick wins over the tick.
- R12: A channel whose run bit is 0 holds its counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq | output | NUM_CH | Per-channel interrupt request |

## Verification
The hardest cases to reach from the ports are the ones where a bus write has to land on the same clock edge as a prescaled tick: a flag clear that meets a match, or a counter write that meets an advance. The stimulus gets there by finding the exact cycle of one match through polling the interrupt, then counting a whole number of prescale periods from that point, so the next write lands on the edge of the following tick. The same cycle counting, with a stop placed a few clocks off a tick boundary, shows whether the prescaler restarts from zero after the run bit is cleared.

// File: rtl/cmt_pkg.sv
`timescale 1ns/1ps
package cmt_pkg;

  localparam int unsigned CH_SPAN  = 16;
  localparam int unsigned IE_POS   = 6;
  localparam int unsigned WRAP_POS = 14;

  typedef enum logic [1:0] {SEL_NONE, SEL_CSR, SEL_CNT, SEL_CMP} sel_e;

  typedef struct packed {
    logic [31:0] value;
    logic        match;
    logic        wrap;
  } step_t;

  function automatic int unsigned presc_ratio(input bit wide);
    return wide ? 8 : 512;
  endfunction

  function automatic int unsigned cnt_width(input bit wide);
    return wide ? 32 : 16;
  endfunction

  function automatic int unsigned flag_pos(input bit wide);
    return wide ? 15 : 7;
  endfunction

  function automatic int unsigned reg_stride(input bit wide);
    return wide ? 4 : 2;
  endfunction

  // One counter step on a tick: compare first, then the natural roll-over.
  function automatic step_t count_step(input logic [31:0] cnt,
                                       input logic [31:0] cmp,
                                       input logic [31:0] top);
    step_t s;
    s = '0;
    if (cnt == cmp) begin
      s.match = 1'b1;
    end else if (cnt == top) begin
      s.wrap = 1'b1;
    end else begin
      s.value = cnt + 32'd1;
    end
    return s;
  endfunction

endpackage

// File: rtl/cmt_prescaler.sv
`timescale 1ns/1ps
module cmt_prescaler #(
  parameter int unsigned RATIO = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned PW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

  logic [PW-1:0] pcnt;

  assign tick = run && (pcnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
    end else if (!run || pcnt == LAST) begin
      pcnt <= '0;
    end else begin
      pcnt <= pcnt + PW'(1);
    end
  end
endmodule

// File: rtl/cmt_channel.sv
`timescale 1ns/1ps
module cmt_channel
  import cmt_pkg::*;
#(
  parameter bit WIDE = 1'b0,
  parameter int unsigned CW = cnt_width(WIDE),
  parameter int unsigned PRESC = presc_ratio(WIDE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          csr_we,
  input  logic          cnt_we,
  input  logic          cmp_we,
  input  logic [31:0]   wdata,
  output logic [15:0]   csr_rd,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cmp_q,
  output logic          irq,
  output logic          tick_o,
  output logic          match_o,
  output logic          wrap_o,
  output logic          flag_o,
  output logic          ie_o
);
  localparam int unsigned FPOS = flag_pos(WIDE);
  localparam logic [31:0] TOP = (CW >= 32) ? 32'hFFFF_FFFF : ((32'd1 << CW) - 32'd1);

  logic  tick;
  step_t step;
  logic  flag_q, ie_q, wrap_q;

  cmt_prescaler #(.RATIO(PRESC)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (tick)
  );

  assign step    = count_step(32'(cnt_q), 32'(cmp_q), TOP);
  assign match_o = tick && step.match;
  assign wrap_o  = tick && step.wrap;
  assign tick_o  = tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_we) begin
      cnt_q <= wdata[CW-1:0];
    end else if (tick) begin
      cnt_q <= step.value[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '1;
    end else if (cmp_we) begin
      cmp_q <= wdata[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (csr_we) ie_q <= wdata[IE_POS];
      if (match_o) begin
        flag_q <= 1'b1;
      end else if (csr_we && !wdata[FPOS]) begin
        flag_q <= 1'b0;
      end
    end
  end

  generate
    if (WIDE) begin : g_wrap
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          wrap_q <= 1'b0;
        end else if (wrap_o) begin
          wrap_q <= 1'b1;
        end else if (csr_we && !wdata[WRAP_POS]) begin
          wrap_q <= 1'b0;
        end
      end
    end else begin : g_nowrap
      assign wrap_q = 1'b0;
    end
  endgenerate

  always_comb begin
    csr_rd           = '0;
    csr_rd[FPOS]     = flag_q;
    csr_rd[IE_POS]   = ie_q;
    csr_rd[WRAP_POS] = wrap_q;
  end

  assign irq    = flag_q & ie_q;
  assign flag_o = flag_q;
  assign ie_o   = ie_q;
endmodule

// File: rtl/cmt_regbus.sv
`timescale 1ns/1ps
module cmt_regbus
  import cmt_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter bit WIDE = 1'b0,
  parameter int unsigned AW = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [AW-1:0]                addr,
  input  logic [31:0]                  wdata,
  input  logic                         wr,
  input  logic                         rd,
  input  logic [NUM_CH-1:0][15:0]      csr_rd,
  input  logic [NUM_CH-1:0][31:0]      cnt_rd,
  input  logic [NUM_CH-1:0][31:0]      cmp_rd,
  output logic [NUM_CH-1:0]            run,
  output logic [NUM_CH-1:0]            csr_we,
  output logic [NUM_CH-1:0]            cnt_we,
  output logic [NUM_CH-1:0]            cmp_we,
  output logic [31:0]                  rdata
);
  localparam int unsigned STRIDE = reg_stride(WIDE);

  function automatic sel_e reg_sel(input logic [AW-1:0] a, input int unsigned c);
    int unsigned base, ai, off;
    base = CH_SPAN * (c + 1);
    ai   = 32'(a);
    if (ai >= base && ai < base + CH_SPAN) begin
      off = ai - base;
      if ((off % STRIDE) == 0) begin
        case (off / STRIDE)
          0: return SEL_CSR;
          1: return SEL_CNT;
          2: return SEL_CMP;
          default: return SEL_NONE;
        endcase
      end
    end
    return SEL_NONE;
  endfunction

  logic        run_hit;
  logic [31:0] rmux;
  sel_e        sel [NUM_CH];

  assign run_hit = (addr == '0);

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
      assign sel[c]    = reg_sel(addr, c);
      assign csr_we[c] = wr && (sel[c] == SEL_CSR);
      assign cnt_we[c] = wr && (sel[c] == SEL_CNT);
      assign cmp_we[c] = wr && (sel[c] == SEL_CMP);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= '0;
    end else if (wr && run_hit) begin
      run <= wdata[NUM_CH-1:0];
    end
  end

  always_comb begin
    rmux = '0;
    if (run_hit) rmux = 32'(run);
    for (int c = 0; c < NUM_CH; c++) begin
      case (sel[c])
        SEL_CSR: rmux = 32'(csr_rd[c]);
        SEL_CNT: rmux = cnt_rd[c];
        SEL_CMP: rmux = cmp_rd[c];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd) begin
      rdata <= rmux;
    end
  end
endmodule

// File: rtl/cmt_timer.sv
`timescale 1ns/1ps
module cmt_timer
  import cmt_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter bit WIDE = 1'b0,
  parameter int unsigned AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  localparam int unsigned CW    = cnt_width(WIDE);
  localparam int unsigned PRESC = presc_ratio(WIDE);

  // Internal events, named for the checker.
  logic [NUM_CH-1:0]          run_v, tick_v, match_v, wrap_v, flag_v, ie_v;
  logic [NUM_CH-1:0]          csr_we_v, cnt_we_v, cmp_we_v;
  logic [NUM_CH-1:0][15:0]    csr_v;
  logic [NUM_CH-1:0][CW-1:0]  cnt_v, cmp_v;
  logic [NUM_CH-1:0][31:0]    cnt32, cmp32;

  cmt_regbus #(.NUM_CH(NUM_CH), .WIDE(WIDE), .AW(AW)) u_bus (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .wr    (bus_wr),
    .rd    (bus_rd),
    .csr_rd(csr_v),
    .cnt_rd(cnt32),
    .cmp_rd(cmp32),
    .run   (run_v),
    .csr_we(csr_we_v),
    .cnt_we(cnt_we_v),
    .cmp_we(cmp_we_v),
    .rdata (bus_rdata)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      cmt_channel #(.WIDE(WIDE), .CW(CW), .PRESC(PRESC)) u_ch (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_v[c]),
        .csr_we (csr_we_v[c]),
        .cnt_we (cnt_we_v[c]),
        .cmp_we (cmp_we_v[c]),
        .wdata  (bus_wdata),
        .csr_rd (csr_v[c]),
        .cnt_q  (cnt_v[c]),
        .cmp_q  (cmp_v[c]),
        .irq    (irq[c]),
        .tick_o (tick_v[c]),
        .match_o(match_v[c]),
        .wrap_o (wrap_v[c]),
        .flag_o (flag_v[c]),
        .ie_o   (ie_v[c])
      );
      assign cnt32[c] = 32'(cnt_v[c]);
      assign cmp32[c] = 32'(cmp_v[c]);
    end
  endgenerate
endmodule

// File: rtl/cmt_timer_chk.sv
`timescale 1ns/1ps
module cmt_timer_chk #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned CW = 16,
  parameter int unsigned PRESC = 512
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_CH-1:0]          run,
  input logic [NUM_CH-1:0]          tick,
  input logic [NUM_CH-1:0]          match,
  input logic [NUM_CH-1:0]          flag,
  input logic [NUM_CH-1:0]          ie,
  input logic [NUM_CH-1:0]          irq,
  input logic [NUM_CH-1:0]          cnt_we,
  input logic [NUM_CH-1:0][CW-1:0]  cnt
);
  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      int unsigned gap;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gap <= 0;
        else if (!run[c] || tick[c]) gap <= 0;
        else gap <= gap + 1;
      end

      assert_tick_needs_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick[c] |-> run[c]);

      assert_tick_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick[c] |-> (gap == PRESC - 1));

      assert_match_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        match[c] |=> flag[c]);

      assert_match_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (match[c] && !cnt_we[c]) |=> (cnt[c] == '0));

      assert_irq_rise_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq[c]) |-> ($rose(flag[c]) || $rose(ie[c])));

      assert_flag_set_by_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag[c]) |-> $past(match[c]));

      assert_stopped_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!run[c] && !cnt_we[c]) |=> (cnt[c] == $past(cnt[c])));
    end
  endgenerate
endmodule

bind cmt_timer cmt_timer_chk #(.NUM_CH(NUM_CH), .CW(CW), .PRESC(PRESC)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .run   (run_v),
  .tick  (tick_v),
  .match (match_v),
  .flag  (flag_v),
  .ie    (ie_v),
  .irq   (irq),
  .cnt_we(cnt_we_v),
  .cnt   (cnt_v)
);

// File: tb/tb_cmt_timer.sv
`timescale 1ns/1ps
module tb_cmt_timer;
  localparam int PW = 8;    // wide prescale ratio
  localparam int PN = 512;  // narrow prescale ratio

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [7:0]  addr_w = '0, addr_n = '0;
  logic [31:0] wd_w = '0, wd_n = '0;
  logic        wr_w = 1'b0, rd_w = 1'b0, wr_n = 1'b0, rd_n = 1'b0;
  logic [31:0] rdata_w, rdata_n;
  logic [1:0]  irq_w, irq_n;

  cmt_timer #(.NUM_CH(2), .WIDE(1'b1), .AW(8)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr_w), .bus_wdata(wd_w),
    .bus_wr(wr_w), .bus_rd(rd_w), .bus_rdata(rdata_w), .irq(irq_w));

  cmt_timer #(.NUM_CH(2), .WIDE(1'b0), .AW(8)) dut_n (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr_n), .bus_wdata(wd_n),
    .bus_wr(wr_n), .bus_rd(rd_n), .bus_rdata(rdata_n), .irq(irq_n));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit          nar;
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  logic rdq_w = 1'b0, rdq_n = 1'b0;
  always @(posedge clk) begin
    rdq_w <= rd_w;
    rdq_n <= rd_n;
  end

  // Monitor: pops one expected item per completed read.
  always @(negedge clk) begin
    if (rdq_w || rdq_n) begin
      checks++;
      if (sbq.size() == 0) begin
        errors++;
        $display("FAIL read with empty scoreboard");
      end else begin
        exp_t it;
        logic [31:0] got;
        it  = sbq.pop_front();
        got = it.nar ? rdata_n : rdata_w;
        if (got !== it.exp) begin
          errors++;
          $display("FAIL %s got %h exp %h", it.tag, got, it.exp);
        end
      end
    end
  end

  task automatic wr(input bit nar, input logic [7:0] a, input logic [31:0] d);
    if (nar) begin addr_n = a; wd_n = d; wr_n = 1'b1; end
    else     begin addr_w = a; wd_w = d; wr_w = 1'b1; end
    @(negedge clk);
    wr_n = 1'b0;
    wr_w = 1'b0;
  endtask

  task automatic rd_exp(input bit nar, input logic [7:0] a, input logic [31:0] e,
                        input string tag);
    exp_t it;
    it.nar = nar; it.exp = e; it.tag = tag;
    sbq.push_back(it);
    if (nar) begin addr_n = a; rd_n = 1'b1; end
    else     begin addr_w = a; rd_w = 1'b1; end
    @(negedge clk);
    rd_n = 1'b0;
    rd_w = 1'b0;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] got,
                     input logic [31:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, e);
    end
  endtask

  task automatic wait_irq(input bit nar, input int ch, output int k);
    k = 0;
    while (!(nar ? irq_n[ch] : irq_w[ch]) && k < 5000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_exp(0, 8'h00, 32'h0, "R1 run reg");
    rd_exp(0, 8'h10, 32'h0, "R1 csr");
    rd_exp(0, 8'h14, 32'h0, "R1 counter");
    rd_exp(0, 8'h18, 32'hFFFF_FFFF, "R1 wide compare");
    rd_exp(1, 8'h14, 32'h0000_FFFF, "R1 narrow compare");
    rd_exp(1, 8'h10, 32'h0, "R1 narrow csr");
    chk(irq_w == 2'b00 && irq_n == 2'b00, "R1 irq idle", {30'b0, irq_w}, 32'h0);

    // R2 / R3 map and widths
    wr(0, 8'h14, 32'hDEAD_BEEF);
    rd_exp(0, 8'h14, 32'hDEAD_BEEF, "R3 wide counter 32 bit");
    wr(0, 8'h28, 32'h1234_5678);
    rd_exp(0, 8'h28, 32'h1234_5678, "R2 ch1 compare");
    rd_exp(0, 8'h24, 32'h0, "R2 ch1 counter untouched");
    wr(1, 8'h12, 32'h0001_2345);
    rd_exp(1, 8'h12, 32'h0000_2345, "R3 narrow counter 16 bit");
    wr(1, 8'h24, 32'h0000_ABCD);
    rd_exp(1, 8'h24, 32'h0000_ABCD, "R2 narrow ch1 compare");
    rd_exp(1, 8'h14, 32'h0000_FFFF, "R2 narrow ch0 compare kept");
    rd_exp(0, 8'h1C, 32'h0, "R2 unmapped");
    rd_exp(0, 8'h12, 32'h0, "R2 misaligned");
    rd_exp(1, 8'h16, 32'h0, "R2 narrow unmapped");
    wr(0, 8'h10, 32'hFFFF_0040);
    rd_exp(0, 8'h10, 32'h0000_0040, "R9 write one keeps flags clear, R3 csr 16 bit");

    // R5 counting, R4, R12
    wr(0, 8'h14, 32'h0);
    wr(0, 8'h00, 32'h1);
    repeat (42) @(negedge clk);
    wr(0, 8'h00, 32'h0);
    rd_exp(0, 8'h14, 32'd5, "R5 five ticks in 43 clocks");
    rd_exp(0, 8'h24, 32'h0, "R4 other channel idle");
    repeat (40) @(negedge clk);
    rd_exp(0, 8'h14, 32'd5, "R12 stopped holds");

    // R11 live read
    wr(0, 8'h00, 32'h1);
    repeat (19) @(negedge clk);
    rd_exp(0, 8'h14, 32'd7, "R11 live counter");
    rd_exp(0, 8'h00, 32'h1, "R4 run readback");
    wr(0, 8'h00, 32'h0);
    // R5 prescaler restart
    wr(0, 8'h00, 32'h1);
    repeat (6) @(negedge clk);
    wr(0, 8'h00, 32'h0);
    rd_exp(0, 8'h14, 32'd7, "R5 prescaler reset on stop");

    // R6 / R8 / R9 match on wide ch0
    wr(0, 8'h14, 32'h0);
    wr(0, 8'h18, 32'd3);
    wr(0, 8'h10, 32'h40);
    wr(0, 8'h00, 32'h1);
    wait_irq(0, 0, k);
    chk(k == 4 * PW, "R6 match after 4 ticks", k, 4 * PW);
    wr(0, 8'h10, 32'h40);
    chk(irq_w[0] == 1'b0, "R9 write zero clears flag", {31'b0, irq_w[0]}, 32'h0);
    repeat (4 * PW - 2) @(negedge clk);
    wr(0, 8'h10, 32'h40);
    chk(irq_w[0] == 1'b1, "R9 set wins over clear", {31'b0, irq_w[0]}, 32'h1);
    rd_exp(0, 8'h10, 32'h8040, "R6 wide flag bit 15");

    // R7 compare rewrite while running
    wr(0, 8'h18, 32'd6);
    wr(0, 8'h10, 32'h40);
    wait_irq(0, 0, k);
    chk(k == 53, "R7 new compare governs next match", k, 53);

    // R8 disable by writing zero
    wr(0, 8'h10, 32'h0);
    repeat (70) @(negedge clk);
    chk(irq_w[0] == 1'b0, "R8 irq off with enable clear", {31'b0, irq_w[0]}, 32'h0);
    rd_exp(0, 8'h10, 32'h8000, "R8 flag without enable");
    wr(0, 8'h00, 32'h0);

    // R10 wrap flag on wide ch1
    wr(0, 8'h14, 32'h55);
    wr(0, 8'h24, 32'hFFFF_FFFE);
    wr(0, 8'h00, 32'h2);
    repeat (18) @(negedge clk);
    wr(0, 8'h00, 32'h0);
    rd_exp(0, 8'h20, 32'h4000, "R10 wrap flag bit 14");
    rd_exp(0, 8'h24, 32'h0, "R10 counter wrapped to zero");
    chk(irq_w[1] == 1'b0, "R10 wrap raises no irq", {31'b0, irq_w[1]}, 32'h0);
    rd_exp(0, 8'h14, 32'h55, "R4 ch0 untouched by ch1 run");
    wr(0, 8'h20, 32'h0);
    rd_exp(0, 8'h20, 32'h0, "R9 wrap flag cleared by zero");

    // R11 counter write wins over tick
    wr(0, 8'h24, 32'h0);
    wr(0, 8'h00, 32'h2);
    repeat (15) @(negedge clk);
    wr(0, 8'h24, 32'h100);
    wr(0, 8'h00, 32'h0);
    rd_exp(0, 8'h24, 32'h100, "R11 counter write wins over tick");

    // Narrow variant: R5 512 ratio, R6 flag bit 7
    wr(1, 8'h12, 32'h0);
    wr(1, 8'h14, 32'd1);
    wr(1, 8'h10, 32'h40);
    wr(1, 8'h00, 32'h1);
    wait_irq(1, 0, k);
    chk(k == 2 * PN, "R5 narrow 512 clock ratio", k, 2 * PN);
    rd_exp(1, 8'h10, 32'h00C0, "R6 narrow flag bit 7");
    wr(1, 8'h10, 32'h0);
    rd_exp(1, 8'h10, 32'h0, "R8 narrow csr cleared");
    chk(irq_n[0] == 1'b0, "R8 narrow irq off", {31'b0, irq_n[0]}, 32'h0);

    repeat (3) @(negedge clk);
    if (sbq.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard left %0d items", sbq.size());
    end
    finish_run();
  end
endmodule